// File: doc/BRIEF.md
# Power-Save Clock Divider Controller

This block produces a CPU clock and two general clock outputs from one fundamental clock. A strap sampled while reset is held picks the fundamental rate. The block is clocked by a fast timing clock `clk`. With the strap high, the fundamental clock runs at the multiplied rate and has a period of two `clk` cycles. With the strap low, it runs at the plain input rate, four times slower, with a period of eight `clk` cycles. The multiplied source is assumed to be phase-locked and supplied from outside.

A power-save divider slows the CPU clock by a power of two, from 1 to 128. The peripherals keep running at the reduced rate. A hardware interrupt drops the block out of power-save without software action. A software interrupt or trap leaves power-save as it is. A new divisor, or the return to full speed, is applied only where a CPU clock period completes, so the CPU clock never carries a shortened phase.

Each of the two clock outputs picks either the fundamental clock or the CPU clock, and each has its own drive enable. A single control word, written through `wr_en`/`wr_data` and always visible on `rd_data`, holds all of these settings.

Top module: `psclk_ctrl`

## Requirements
- R1: While `rst_n` is low, `fund_clk`, `cpu_clk` and both `clk_out` bits are 0. The control word resets to 0xC0: power-save off, divisor code 0, both outputs select the fundamental clock, both drives enabled.
- R2: `strap_mul` is sampled only while reset is held. When it is 1, `fund_clk` has a period of 2 `clk` cycles (1 high, 1 low). When it is 0, the period is 8 cycles (4 high, 4 low). Changes to `strap_mul` after reset have no effect.
- R3: With power-save on and divisor code k, `cpu_clk` has 50 % duty and each of its phases lasts 2^k fundamental half-periods. Every `cpu_clk` edge coincides with a `fund_clk` edge.
- R4: With power-save off, each `cpu_clk` phase lasts one fundamental half-period, whatever the divisor code.
- R5: The control word layout is as follows. Bits 2:0 hold the divisor code k (divide by 2^k). Bit 3 enables power-save. Bits 5:4 select the source for outputs 1:0 (0 = fundamental, 1 = CPU clock). Bits 7:6 are the drive enables for outputs 1:0. A write on `wr_en` loads the whole word, and `rd_data` shows the word from the cycle after the write.
- R6: `irq_valid` with `irq_is_hw` = 1 clears bit 3 on the next clock edge. This takes priority over a write to the control word in the same cycle.
- R7: `irq_valid` with `irq_is_hw` = 0 (software interrupt or trap) leaves bit 3 and the CPU clock rate unchanged.
- R8: Each `clk_out[i]` whose drive is enabled follows `fund_clk` when its select bit is 0 and `cpu_clk` when it is 1.
- R9: Each `clk_out[i]` whose drive enable is 0 is held low.
- R10: A change of divisor, or an exit from power-save, takes effect at the next falling edge of `cpu_clk`. The phase in progress when the change is made finishes at its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock (twice the multiplied fundamental rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_mul | input | 1 | Fundamental source strap, sampled during reset (1 = multiplied) |
| wr_en | input | 1 | Load the control word |
| wr_data | input | 8 | New control word |
| rd_data | output | 8 | Current control word |
| irq_valid | input | 1 | Interrupt event, one cycle |
| irq_is_hw | input | 1 | Event is a hardware interrupt (1) or software interrupt/trap (0) |
| fund_clk | output | 1 | Fundamental clock |
| cpu_clk | output | 1 | Power-save divided CPU clock |
| clk_out | output | 2 | Selectable, individually enabled clock outputs |

## Verification
The hardest case to reach is a divisor change or hardware-interrupt exit that lands in the middle of a slow CPU clock phase. In that case the phase must still finish at its old length, and the new rate must begin exactly at the following falling edge. To get there, the stimulus waits for a rising edge of `cpu_clk` under a divide-by-8 setting with the slow fundamental. It fires the write or the interrupt on the first sample of that high phase. It then measures the length of the high phase in progress and of the low phase that follows. A change applied early shows up as a short high phase, and a change applied late shows up as a long low phase.

// File: rtl/psclk_pkg.sv
// Shared constants and types for the power-save clock controller.
// Assumes: control word layout fixed by the field widths below.
package psclk_pkg;
    localparam int PS_DIV_BITS = 3;
    localparam int PS_NUM_OUT  = 2;
    localparam int PS_CTL_W    = PS_DIV_BITS + 1 + 2 * PS_NUM_OUT;

    // Source choice of one clock output (select bit value).
    typedef enum logic {
        SRC_FUND = 1'b0,
        SRC_CPU  = 1'b1
    } clk_src_e;
endpackage

// File: rtl/psclk_regs.sv
// Control word holding divisor code, power-save enable, output selects and
// drive enables. A hardware interrupt clears the power-save enable and wins
// over a same-cycle write. Assumes irq inputs are synchronous to clk.
module psclk_regs #(
    parameter int DIV_BITS = 3,
    parameter int NUM_OUT  = 2,
    parameter int CTL_W    = DIV_BITS + 1 + 2 * NUM_OUT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CTL_W-1:0]   wr_data,
    input  logic               irq_valid,
    input  logic               irq_is_hw,
    output logic [DIV_BITS-1:0] div_code,
    output logic               ps_en,
    output logic [NUM_OUT-1:0] sel,
    output logic [NUM_OUT-1:0] drv,
    output logic [CTL_W-1:0]   rd_data
);
    localparam int PS_BIT  = DIV_BITS;
    localparam int SEL_LSB = DIV_BITS + 1;
    localparam int DRV_LSB = SEL_LSB + NUM_OUT;
    localparam logic [CTL_W-1:0] RST_WORD =
        {{NUM_OUT{1'b1}}, {NUM_OUT{1'b0}}, 1'b0, {DIV_BITS{1'b0}}};

    logic [CTL_W-1:0] ctl_q;
    logic             hw_exit;

    // Decode a hardware interrupt event.
    assign hw_exit = irq_valid && irq_is_hw;

    // Hold the control word; hardware interrupt overrides the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= RST_WORD;
        end else begin
            if (wr_en) begin
                ctl_q <= wr_data;
            end
            if (hw_exit) begin
                ctl_q[PS_BIT] <= 1'b0;
            end
        end
    end

    // Split the word into its fields.
    assign div_code = ctl_q[DIV_BITS-1:0];
    assign ps_en    = ctl_q[PS_BIT];
    assign sel      = ctl_q[SEL_LSB +: NUM_OUT];
    assign drv      = ctl_q[DRV_LSB +: NUM_OUT];
    assign rd_data  = ctl_q;

    AST_HW_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_is_hw) |=> !ps_en); // R6
    AST_SW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_en && irq_valid && !irq_is_hw && !wr_en) |=> ps_en); // R7
endmodule

// File: rtl/psclk_fund.sv
// Fundamental clock generator. Latches the strap during reset and produces a
// square wave whose half-period is MUL_HALF clk cycles (strap = 1) or
// MUL_HALF*MUL_FACTOR cycles (strap = 0). Also flags each toggle.
// Assumes the strap is steady during the last cycles of reset.
module psclk_fund #(
    parameter int MUL_HALF   = 1,
    parameter int MUL_FACTOR = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_mul,
    output logic fund_q,
    output logic fund_tgl
);
    localparam int BASE_HALF = MUL_HALF * MUL_FACTOR;
    localparam int CW        = $clog2(BASE_HALF + 1);

    logic          strap_q;
    logic [CW-1:0] fcnt;
    logic [CW-1:0] half_m1;

    // Capture the strap only while reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q <= strap_mul;
        end
    end

    // Terminal count of one fundamental half-period.
    assign half_m1  = strap_q ? CW'(MUL_HALF - 1) : CW'(BASE_HALF - 1);
    assign fund_tgl = (fcnt == half_m1);

    // Count half-periods and toggle the fundamental clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt   <= '0;
            fund_q <= 1'b0;
        end else if (fund_tgl) begin
            fcnt   <= '0;
            fund_q <= ~fund_q;
        end else begin
            fcnt   <= fcnt + 1'b1;
        end
    end

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(strap_q)); // R2
endmodule

// File: rtl/psclk_div.sv
// Power-save divider. Counts fundamental half-periods and toggles the CPU
// clock every 2^k of them. The active code k is reloaded only when a full
// CPU period ends (high-to-low toggle), so no phase is ever shortened.
// Assumes fund_tgl marks every fundamental edge.
module psclk_div #(
    parameter int DIV_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fund_q,
    input  logic                fund_tgl,
    input  logic                ps_en,
    input  logic [DIV_BITS-1:0] div_code,
    output logic                cpu_q
);
    localparam int MAXK = (1 << DIV_BITS) - 1;
    localparam int HW   = MAXK;

    logic [DIV_BITS-1:0] act_k;
    logic [DIV_BITS-1:0] eff_k;
    logic [HW-1:0]       hcnt;
    logic [HW-1:0]       limit;
    logic                cpu_tgl;

    // Requested code: full speed whenever power-save is off.
    assign eff_k   = ps_en ? div_code : '0;
    // Last half-period index of a CPU phase: 2^act_k - 1.
    assign limit   = {HW{1'b1}} >> (DIV_BITS'(MAXK) - act_k);
    assign cpu_tgl = fund_tgl && (hcnt == limit);

    // Advance the phase counter and toggle the CPU clock at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt  <= '0;
            cpu_q <= 1'b0;
            act_k <= '0;
        end else if (cpu_tgl) begin
            hcnt  <= '0;
            cpu_q <= ~cpu_q;
            if (cpu_q) begin
                act_k <= eff_k;
            end
        end else if (fund_tgl) begin
            hcnt  <= hcnt + 1'b1;
        end
    end

    AST_SWITCH_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_k) |-> $fell(cpu_q)); // R10
    AST_CPU_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cpu_q) |-> !$stable(fund_q)); // R3
endmodule

// File: rtl/psclk_outsel.sv
// Output stage: for each output, pick fundamental or CPU clock and gate it
// with its drive enable; a disabled output sits low.
// Assumes select/enable changes are rare and made by software.
module psclk_outsel #(
    parameter int NUM_OUT = 2
) (
    input  logic               fund_q,
    input  logic               cpu_q,
    input  logic [NUM_OUT-1:0] sel,
    input  logic [NUM_OUT-1:0] drv,
    output logic [NUM_OUT-1:0] clk_out
);
    import psclk_pkg::*;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        // Source mux and drive gate for output i.
        always_comb begin
            clk_out[i] = 1'b0;
            if (drv[i]) begin
                clk_out[i] = (clk_src_e'(sel[i]) == SRC_CPU) ? cpu_q : fund_q;
            end
        end
    end
endmodule

// File: rtl/psclk_ctrl.sv
// Top of the power-save clock controller: control word, fundamental
// generator, boundary-safe power-save divider and output selection.
// Assumes clk runs at twice the multiplied fundamental rate.
module psclk_ctrl
    import psclk_pkg::*;
#(
    parameter int DIV_BITS   = PS_DIV_BITS,
    parameter int NUM_OUT    = PS_NUM_OUT,
    parameter int MUL_HALF   = 1,
    parameter int MUL_FACTOR = 4,
    parameter int CTL_W      = DIV_BITS + 1 + 2 * NUM_OUT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strap_mul,
    input  logic               wr_en,
    input  logic [CTL_W-1:0]   wr_data,
    output logic [CTL_W-1:0]   rd_data,
    input  logic               irq_valid,
    input  logic               irq_is_hw,
    output logic               fund_clk,
    output logic               cpu_clk,
    output logic [NUM_OUT-1:0] clk_out
);
    logic [DIV_BITS-1:0] div_code;
    logic                ps_en;
    logic [NUM_OUT-1:0]  sel;
    logic [NUM_OUT-1:0]  drv;
    logic                fund_tgl;

    psclk_regs #(.DIV_BITS(DIV_BITS), .NUM_OUT(NUM_OUT), .CTL_W(CTL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .irq_valid(irq_valid), .irq_is_hw(irq_is_hw),
        .div_code(div_code), .ps_en(ps_en), .sel(sel), .drv(drv),
        .rd_data(rd_data)
    );

    psclk_fund #(.MUL_HALF(MUL_HALF), .MUL_FACTOR(MUL_FACTOR)) u_fund (
        .clk(clk), .rst_n(rst_n), .strap_mul(strap_mul),
        .fund_q(fund_clk), .fund_tgl(fund_tgl)
    );

    psclk_div #(.DIV_BITS(DIV_BITS)) u_div (
        .clk(clk), .rst_n(rst_n), .fund_q(fund_clk), .fund_tgl(fund_tgl),
        .ps_en(ps_en), .div_code(div_code), .cpu_q(cpu_clk)
    );

    psclk_outsel #(.NUM_OUT(NUM_OUT)) u_out (
        .fund_q(fund_clk), .cpu_q(cpu_clk), .sel(sel), .drv(drv),
        .clk_out(clk_out)
    );
endmodule

// File: tb/tb_psclk_ctrl.sv
// Directed bench for psclk_ctrl: one task per scenario, each self-checking.
module tb_psclk_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_mul = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_valid = 1'b0;
    logic       irq_is_hw = 1'b0;
    logic       fund_clk;
    logic       cpu_clk;
    logic [1:0] clk_out;

    int n_chk = 0;
    int n_bad = 0;

    psclk_ctrl dut (
        .clk(clk), .rst_n(rst_n), .strap_mul(strap_mul),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .irq_valid(irq_valid), .irq_is_hw(irq_is_hw),
        .fund_clk(fund_clk), .cpu_clk(cpu_clk), .clk_out(clk_out)
    );

    always #10 clk = ~clk;   // 50 MHz with a 1 ns time unit

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; strap_mul = strap;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_ctl(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic pick(input bit use_cpu);
        return use_cpu ? cpu_clk : fund_clk;
    endfunction

    task automatic align(input bit use_cpu);
        logic prev;
        prev = pick(use_cpu);
        do @(negedge clk); while (pick(use_cpu) == prev);
    endtask

    task automatic align_rise;
        do align(1'b1); while (cpu_clk != 1'b1);
    endtask

    // Continue measuring the current phase of the chosen clock.
    task automatic phase_from(input bit use_cpu, input int start, output int len);
        logic lvl;
        lvl = pick(use_cpu);
        len = start;
        forever begin
            @(negedge clk);
            if (pick(use_cpu) != lvl || len > 4000) break;
            len++;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(fund_clk == 0 && cpu_clk == 0 && clk_out == 0, "R1 outputs in reset",
              {29'd0, fund_clk, cpu_clk, clk_out[0]}, 0);
        check(rd_data == 8'hC0, "R1 reset word", rd_data, 8'hC0);
        rst_n = 1'b1;
    endtask

    task automatic t_strap;
        int len;
        do_reset(1'b0);
        strap_mul = 1'b1;   // ignored after reset
        align(1'b0);
        phase_from(1'b0, 1, len); check(len == 4, "R2 slow fund phase", len, 4);
        phase_from(1'b0, 1, len); check(len == 4, "R2 slow fund phase after strap change", len, 4);
        do_reset(1'b1);
        strap_mul = 1'b0;
        align(1'b0);
        phase_from(1'b0, 1, len); check(len == 1, "R2 fast fund phase", len, 1);
        phase_from(1'b0, 1, len); check(len == 1, "R2 fast fund phase after strap change", len, 1);
    endtask

    task automatic t_divs;
        int hi, lo;
        for (int k = 0; k < 8; k++) begin
            write_ctl(8'hC8 | 8'(k));
            check(rd_data == (8'hC8 | 8'(k)), "R5 readback", rd_data, 8'hC8 | k);
            repeat (600) @(negedge clk);
            align_rise;
            phase_from(1'b1, 1, hi);
            phase_from(1'b1, 1, lo);
            check(hi == (1 << k), "R3 high phase", hi, 1 << k);
            check(lo == (1 << k), "R3 low phase", lo, 1 << k);
        end
        write_ctl(8'hC7);   // code 7, power-save off
        repeat (600) @(negedge clk);
        align_rise;
        phase_from(1'b1, 1, hi);
        check(hi == 1, "R4 divider bypassed when off", hi, 1);
    endtask

    task automatic t_outputs;
        int bad;
        for (int s = 0; s < 4; s++) begin
            for (int d = 0; d < 4; d++) begin
                write_ctl(8'(d << 6) | 8'(s << 4) | 8'h0A);
                bad = 0;
                for (int c = 0; c < 64; c++) begin
                    @(negedge clk);
                    for (int i = 0; i < 2; i++) begin
                        logic e;
                        e = d[i] ? (s[i] ? cpu_clk : fund_clk) : 1'b0;
                        if (clk_out[i] != e) bad++;
                    end
                end
                if (d != 3) check(bad == 0, "R9 disabled output low", bad, 0);
                else        check(bad == 0, "R8 output source select", bad, 0);
            end
        end
    endtask

    task automatic t_hw_exit;
        int hi, lo;
        do_reset(1'b0);
        write_ctl(8'hCB);   // power-save, code 3: phases of 32 cycles
        repeat (600) @(negedge clk);
        align_rise;
        irq_valid = 1'b1; irq_is_hw = 1'b1;
        @(negedge clk);
        irq_valid = 1'b0; irq_is_hw = 1'b0;
        check(rd_data[3] == 1'b0, "R6 hw interrupt clears enable", rd_data[3], 0);
        phase_from(1'b1, 2, hi);
        check(hi == 32, "R10 phase completes before exit", hi, 32);
        phase_from(1'b1, 1, lo);
        check(lo == 4, "R6 full speed after boundary", lo, 4);
        // Hardware interrupt beats a same-cycle write.
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'hCB; irq_valid = 1'b1; irq_is_hw = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; irq_valid = 1'b0; irq_is_hw = 1'b0;
        check(rd_data == 8'hC3, "R6 priority over write", rd_data, 8'hC3);
    endtask

    task automatic t_sw_keep;
        int hi, lo;
        write_ctl(8'hCB);
        repeat (600) @(negedge clk);
        @(negedge clk);
        irq_valid = 1'b1; irq_is_hw = 1'b0;
        @(negedge clk);
        irq_valid = 1'b0;
        check(rd_data[3] == 1'b1, "R7 soft interrupt keeps enable", rd_data[3], 1);
        repeat (200) @(negedge clk);
        align_rise;
        phase_from(1'b1, 1, hi);
        phase_from(1'b1, 1, lo);
        check(hi == 32 && lo == 32, "R7 rate unchanged", hi + lo, 64);
    endtask

    task automatic t_div_change;
        int hi, lo;
        align_rise;         // code 3 active from previous scenario
        wr_en = 1'b1; wr_data = 8'hC8;
        @(negedge clk);
        wr_en = 1'b0;
        phase_from(1'b1, 2, hi);
        check(hi == 32, "R10 old divisor finishes phase", hi, 32);
        phase_from(1'b1, 1, lo);
        check(lo == 4, "R10 new divisor from falling edge", lo, 4);
    endtask

    initial begin
        t_reset;
        t_strap;    // leaves strap = 1
        t_divs;
        t_outputs;
        t_hw_exit;  // leaves strap = 0
        t_sw_keep;
        t_div_change;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule